// File: doc/BRIEF.md
# Interrupt Acceptance Flag Controller

This block owns the processor status word of a small CPU core: four arithmetic condition flags, a debug flag, a register bank select, an interrupt enable, a stack select and a 3-bit processor priority level. The execute stage feeds it ALU results with a per-flag update mask, and software can load the whole word through an explicit write port. The block also decides whether an incoming interrupt request is taken.

Hardware requests are maskable. One is acknowledged only while interrupts are enabled and its priority is strictly above the current processor level. Software interrupts are always acknowledged. On acknowledge the block raises its acknowledge output in the same cycle and shows the pre-acknowledge status word on a save output, so the core can push it. On the next edge it clears the enable flag, loads the processor level with the request's priority and, where the request calls for it, switches to the interrupt stack. Vector fetch and stacking to memory belong to other blocks.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every status bit and the processor level are 0, and acknowledge and save outputs are 0 while no request is present.
- R2: The status word is laid out as carry bit 0, debug bit 1, zero bit 2, sign bit 3, bank bit 4, overflow bit 5, enable bit 6, stack select bit 7, level bits 10:8. An explicit write loads all 11 bits on the next edge.
- R3: The ALU update mask is bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow. Masked carry and overflow take the ALU carry and overflow inputs on the next edge. Flags outside the mask keep their value.
- R4: Masked zero is 1 exactly when the result is 0, and masked sign is the result's top bit. In byte mode only the low half of the result counts. In word mode the full width counts.
- R5: When an explicit write and an ALU update fall in the same cycle, the written value wins for every flag.
- R6: A hardware request is acknowledged in its own cycle only when enable is 1 and its priority is strictly greater than the processor level.
- R7: A software request is acknowledged in its own cycle regardless of enable and level.
- R8: Every acknowledge clears the enable flag on the next edge.
- R9: A hardware acknowledge, or a software acknowledge numbered 0 to 31, clears stack select on the next edge. A software acknowledge numbered 32 or above leaves stack select unchanged.
- R10: Every acknowledge loads the processor level with the request's priority on the next edge.
- R11: During an acknowledge cycle the save output equals the status word held before that edge.
- R12: When an explicit write meets an acknowledge, the acknowledge sets enable, stack select and level, and the written value sets all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_mask_i | input | 4 | Per-flag ALU update mask {overflow, sign, zero, carry} |
| alu_res_i | input | DATA_W | ALU result used for zero and sign |
| alu_byte_i | input | 1 | 1 selects byte-sized result |
| alu_carry_i | input | 1 | ALU carry, borrow or shift-out bit |
| alu_ovf_i | input | 1 | ALU overflow |
| flg_we_i | input | 1 | Explicit status word write strobe |
| flg_wdata_i | input | 11 | Explicit status word write data |
| irq_req_i | input | 1 | Interrupt request present |
| irq_hw_i | input | 1 | 1 for hardware request, 0 for software |
| irq_lvl_i | input | 3 | Request priority |
| irq_num_i | input | NUM_W | Software interrupt number |
| irq_ack_o | output | 1 | Request acknowledged this cycle |
| flg_o | output | 11 | Current status word |
| flg_save_o | output | 11 | Status word to save, valid during acknowledge |

## Verification
Acknowledge and save are combinational, so the bench drives a request after a falling edge and samples them 1 ns later in the same cycle. Every status update, whether from the ALU, an explicit write or an acknowledge, passes one register and is sampled 1 ns after the following rising edge. Inputs are then cleared, so a missed or extra update shows at the next sample. Gating checks that expect no acknowledge also read the status word after the edge, which confirms that it did not move.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int LVL_W = 3;
  localparam int FLG_W = 8 + LVL_W;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic u;
    logic i;
    logic o;
    logic b;
    logic s;
    logic z;
    logic d;
    logic c;
  } flg_t;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic c;
  } alu_mask_t;
endpackage

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              byte_i,
  output logic              z_o,
  output logic              s_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (byte_i) begin
      z_o = (res_i[HALF_W-1:0] == '0);
      s_o = res_i[HALF_W-1];
    end else begin
      z_o = (res_i == '0);
      s_o = res_i[DATA_W-1];
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_flag_pkg::*;
#(
  parameter int NUM_W        = 6,
  parameter int SW_STK_LIMIT = 32
) (
  input  logic             req_i,
  input  logic             hw_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             ien_i,
  input  logic [LVL_W-1:0] ipl_i,
  output logic             ack_o,
  output logic             clr_stk_o
);
  logic hw_ok;

  assign hw_ok     = ien_i && (lvl_i > ipl_i);
  assign ack_o     = req_i && (!hw_i || hw_ok);
  // low-numbered software traps also move to the interrupt stack
  assign clr_stk_o = ack_o && (hw_i || (int'(num_i) < SW_STK_LIMIT));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int NUM_W        = 6,
  parameter int SW_STK_LIMIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        alu_mask_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_byte_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  input  logic              flg_we_i,
  input  logic [10:0]       flg_wdata_i,
  input  logic              irq_req_i,
  input  logic              irq_hw_i,
  input  logic [2:0]        irq_lvl_i,
  input  logic [NUM_W-1:0]  irq_num_i,
  output logic              irq_ack_o,
  output logic [10:0]       flg_o,
  output logic [10:0]       flg_save_o
);
  flg_t      flg_q, flg_d;
  alu_mask_t mask;
  logic      res_z, res_s;
  logic      clr_stk;

  assign mask = alu_mask_t'(alu_mask_i);

  alu_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .res_i  (alu_res_i),
    .byte_i (alu_byte_i),
    .z_o    (res_z),
    .s_o    (res_s)
  );

  irq_gate #(.NUM_W(NUM_W), .SW_STK_LIMIT(SW_STK_LIMIT)) u_gate (
    .req_i     (irq_req_i),
    .hw_i      (irq_hw_i),
    .lvl_i     (irq_lvl_i),
    .num_i     (irq_num_i),
    .ien_i     (flg_q.i),
    .ipl_i     (flg_q.lvl),
    .ack_o     (irq_ack_o),
    .clr_stk_o (clr_stk)
  );

  always_comb begin
    flg_d = flg_q;
    if (mask.c) flg_d.c = alu_carry_i;
    if (mask.z) flg_d.z = res_z;
    if (mask.s) flg_d.s = res_s;
    if (mask.o) flg_d.o = alu_ovf_i;
    if (flg_we_i) flg_d = flg_t'(flg_wdata_i);
    // acknowledge owns enable, stack select and level
    if (irq_ack_o) begin
      flg_d.i   = 1'b0;
      flg_d.lvl = irq_lvl_i;
      if (clr_stk) flg_d.u = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign flg_o      = flg_q;
  assign flg_save_o = irq_ack_o ? flg_q : '0;

  AST_HW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o && irq_hw_i) |-> (flg_o[6] && (irq_lvl_i > flg_o[10:8]))); // R6
  AST_SW_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !irq_hw_i) |-> irq_ack_o); // R7
  AST_IEN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !flg_o[6]); // R8
  AST_HW_STK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o && irq_hw_i) |=> !flg_o[7]); // R9
  AST_LVL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (flg_o[10:8] == $past(irq_lvl_i))); // R10
  AST_SAVE_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> ($past(flg_save_o) == $past(flg_o))); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_i && !flg_we_i && alu_mask_i == 4'd0) |=> $stable(flg_o)); // R3
endmodule

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_mask;
  logic [15:0] alu_res;
  logic        alu_byte, alu_carry, alu_ovf;
  logic        flg_we;
  logic [10:0] flg_wdata;
  logic        irq_req, irq_hw;
  logic [2:0]  irq_lvl;
  logic [5:0]  irq_num;
  logic        irq_ack;
  logic [10:0] flg, flg_save;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .alu_mask_i(alu_mask), .alu_res_i(alu_res),
    .alu_byte_i(alu_byte), .alu_carry_i(alu_carry), .alu_ovf_i(alu_ovf),
    .flg_we_i(flg_we), .flg_wdata_i(flg_wdata), .irq_req_i(irq_req),
    .irq_hw_i(irq_hw), .irq_lvl_i(irq_lvl), .irq_num_i(irq_num),
    .irq_ack_o(irq_ack), .flg_o(flg), .flg_save_o(flg_save)
  );

  // status word: lvl[10:8] u7 i6 o5 b4 s3 z2 d1 c0
  function automatic logic [10:0] mk(input logic [2:0] lv, input logic u, i, o, b, s, z, d, c);
    return {lv, u, i, o, b, s, z, d, c};
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_mask = 0; alu_res = 0; alu_byte = 0; alu_carry = 0; alu_ovf = 0;
    flg_we = 0; flg_wdata = 0; irq_req = 0; irq_hw = 0; irq_lvl = 0; irq_num = 0;
  endtask

  task automatic wr(input logic [10:0] v);
    @(negedge clk); idle(); flg_we = 1; flg_wdata = v;
    @(posedge clk); #1; idle();
  endtask

  task automatic req(input logic hw, input logic [2:0] lv, input logic [5:0] num,
                     output logic ack, output logic [10:0] sv);
    @(negedge clk); irq_req = 1; irq_hw = hw; irq_lvl = lv; irq_num = num;
    #1; ack = irq_ack; sv = flg_save;
    @(posedge clk); #1; idle();
  endtask

  task automatic t_reset();
    chk("R1 flags", flg, 11'h0);
    chk("R1 ack", {10'd0, irq_ack}, 11'h0);
    chk("R1 save", flg_save, 11'h0);
  endtask

  task automatic t_write();
    wr(11'h5A3);
    chk("R2 write", flg, 11'h5A3);
    wr(11'h000);
    chk("R2 write zero", flg, 11'h0);
  endtask

  task automatic t_alu();
    wr(mk(3'd2, 0, 0, 0, 1, 0, 1, 0, 0));
    @(negedge clk); alu_mask = 4'b1111; alu_res = 16'h8000; alu_carry = 1; alu_ovf = 1;
    @(posedge clk); #1; idle();
    chk("R4 word neg", flg, mk(3'd2, 0, 0, 1, 1, 1, 0, 0, 1));
    @(negedge clk); alu_mask = 4'b0110; alu_res = 16'h1200; alu_byte = 1; alu_carry = 0; alu_ovf = 0;
    @(posedge clk); #1; idle();
    chk("R4 byte zero, R3 c/o kept", flg, mk(3'd2, 0, 0, 1, 1, 0, 1, 0, 1));
    @(negedge clk); alu_mask = 4'b0110; alu_res = 16'h0080; alu_byte = 1;
    @(posedge clk); #1; idle();
    chk("R4 byte neg", flg, mk(3'd2, 0, 0, 1, 1, 1, 0, 0, 1));
    @(negedge clk); alu_mask = 4'b0110; alu_res = 16'h0100; alu_byte = 0;
    @(posedge clk); #1; idle();
    chk("R4 word nonzero", flg, mk(3'd2, 0, 0, 1, 1, 0, 0, 0, 1));
    @(negedge clk); alu_mask = 4'b1001; alu_carry = 0; alu_ovf = 0; alu_res = 16'h0;
    @(posedge clk); #1; idle();
    chk("R3 c/o clear, z/s kept", flg, mk(3'd2, 0, 0, 0, 1, 0, 0, 0, 0));
  endtask

  task automatic t_alu_vs_write();
    @(negedge clk); alu_mask = 4'b1111; alu_res = 16'h0; alu_carry = 1; alu_ovf = 1;
    flg_we = 1; flg_wdata = mk(3'd0, 0, 0, 0, 0, 1, 0, 1, 0);
    @(posedge clk); #1; idle();
    chk("R5 write over alu", flg, mk(3'd0, 0, 0, 0, 0, 1, 0, 1, 0));
  endtask

  task automatic t_hw_gate();
    logic a; logic [10:0] s;
    wr(mk(3'd3, 1, 0, 0, 0, 0, 0, 0, 0));
    req(1, 3'd7, 6'd0, a, s);
    chk("R6 ien=0 no ack", {10'd0, a}, 11'h0);
    chk("R1 save idle", s, 11'h0);
    chk("R6 ien=0 hold", flg, mk(3'd3, 1, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(3'd3, 1, 1, 0, 0, 0, 0, 0, 1));
    req(1, 3'd3, 6'd0, a, s);
    chk("R6 equal lvl no ack", {10'd0, a}, 11'h0);
    chk("R6 equal lvl hold", flg, mk(3'd3, 1, 1, 0, 0, 0, 0, 0, 1));
    req(1, 3'd4, 6'd50, a, s);
    chk("R6 higher ack", {10'd0, a}, 11'h1);
    chk("R11 save", s, mk(3'd3, 1, 1, 0, 0, 0, 0, 0, 1));
    chk("R8 R9 R10 hw ack", flg, mk(3'd4, 0, 0, 0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_sw();
    logic a; logic [10:0] s;
    wr(mk(3'd5, 1, 0, 0, 1, 0, 0, 0, 0));
    req(0, 3'd1, 6'd40, a, s);
    chk("R7 sw ack", {10'd0, a}, 11'h1);
    chk("R11 sw save", s, mk(3'd5, 1, 0, 0, 1, 0, 0, 0, 0));
    chk("R9 num>=32 keeps u", flg, mk(3'd1, 1, 0, 0, 1, 0, 0, 0, 0));
    wr(mk(3'd7, 1, 1, 0, 0, 0, 0, 0, 0));
    req(0, 3'd2, 6'd31, a, s);
    chk("R7 sw ack lvl low", {10'd0, a}, 11'h1);
    chk("R9 num 31 clears u", flg, mk(3'd2, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(3'd0, 1, 1, 0, 0, 0, 0, 0, 0));
    req(0, 3'd6, 6'd32, a, s);
    chk("R9 num 32 keeps u", flg, mk(3'd6, 1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_collide();
    wr(mk(3'd1, 1, 1, 0, 0, 0, 0, 0, 0));
    @(negedge clk); irq_req = 1; irq_hw = 1; irq_lvl = 3'd6;
    flg_we = 1; flg_wdata = 11'h7FF;
    #1; chk("R12 ack", {10'd0, irq_ack}, 11'h1);
    @(posedge clk); #1; idle();
    chk("R12 ack over write", flg, mk(3'd6, 0, 0, 1, 1, 1, 1, 1, 1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_write();
    t_alu();
    t_alu_vs_write();
    t_hw_gate();
    t_sw();
    t_collide();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule